// File: doc/BRIEF.md
# Three-Phase Cyclic Relay Sequencer

This block runs an endless cycle of three timed phases, always in the order first, middle, last, and then back to first. Each phase has its own programmable length, counted in ticks of a one-cycle enable (nominally once per second). Two relay outputs are decoded from the phase. One is on for the whole of the first phase. The other is on for the whole of the last phase. Neither is on during the middle phase.

The phase is held in two set/reset state bits. Finishing the first phase clears one bit. Finishing the middle phase clears the other. Finishing the last phase sets both bits on the same clock edge, which restarts the first phase. Each phase has its own delay counter. Only the active phase's counter runs. The counters of the other two phases are held at zero.

A synchronous active-low reset stands in for the power-up network. It puts the sequencer into the first phase.

Top module: `phase_relay_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, both state bits are set. After that edge, phase reads 2'b01 (first phase), relay_first is 1 and relay_last is 0.
- R2: The phase output takes only the codes 2'b01 (first), 2'b10 (middle) and 2'b11 (last). It moves only from 01 to 10, from 10 to 11, and from 11 back to 01, and it never stops.
- R3: relay_first is 1 exactly while phase is 2'b01, and 0 in the other two phases.
- R4: relay_last is 1 exactly while phase is 2'b11, and 0 in the other two phases.
- R5: A phase with a delay of N ≥ 1 ends on the first clock edge after the edge at which its N-th tick was counted. Once the count reaches N it holds there and does not wrap. A tick that falls in that final cycle is not counted by any phase.
- R6: A phase whose delay is 0 lasts exactly one clock cycle, and counts no tick.
- R7: Only the counter of the active phase advances. The counters of inactive phases are held at zero, so each phase restarts from zero every time it is entered.
- R8: Finishing the last phase sets both state bits on one clock edge, so phase goes straight from 2'b11 to 2'b01. The state code with bit A set and bit B clear never occurs; if it did, it would be forced back to the first phase.
- R9: A reset applied during any phase returns the sequencer to the first phase on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timing enable |
| delay_first | input | DW | Length of the first phase, in ticks |
| delay_mid | input | DW | Length of the middle phase, in ticks |
| delay_last | input | DW | Length of the last phase, in ticks |
| phase | output | 2 | Current phase code: 01, 10 or 11 |
| relay_first | output | 1 | Relay drive, on during the first phase |
| relay_last | output | 1 | Relay drive, on during the last phase |

## Verification
A tick can arrive in the same cycle that a phase completes. The bench provokes this by driving the tick in every cycle, and judges it by requiring a phase of delay N to see N+1 ticks: its N counted ticks plus the one that is dropped. With spaced ticks the same phase must see exactly N ticks.

Completion of the last phase also coincides with the setting of both state bits. This is judged by requiring the observed next phase after the last phase to be the first phase, with no other code in between. Zero delays in a run with a tick every cycle make the completion fall on the very first cycle of a phase.

// File: rtl/seq_pkg.sv
// Package: shared constants for the three-phase relay sequencer.
// Assumes the phase codes below are decoded the same way everywhere.
package seq_pkg;
    localparam int          NUM_PHASES = 3;
    localparam logic [1:0]  PH_FIRST   = 2'b01;
    localparam logic [1:0]  PH_MID     = 2'b10;
    localparam logic [1:0]  PH_LAST    = 2'b11;
endpackage

// File: rtl/seq_phase_timer.sv
// Module: per-phase delay counter.
// Counts ticks while its phase is active and stops at the target value.
// Holds at zero while its phase is inactive. done is combinational.
// Assumes the target is stable while the phase is active.
module seq_phase_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick,
    input  logic [DW-1:0] target,
    output logic          done
);
    logic [DW-1:0] cnt;

    // Count ticks while active, stop at target, clear while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (tick && (cnt != target)) begin
            cnt <= cnt + DW'(1);
        end
    end

    // Completion flag for the state bits.
    assign done = active && (cnt == target);

    AST_IDLE_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0)); // R7
    AST_FREEZE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (cnt == target)) |=> ((cnt == $past(cnt)) || (cnt == '0))); // R5
endmodule

// File: rtl/seq_state_bits.sv
// Module: the two set/reset phase bits.
// Finishing the first phase clears bit A. Finishing the middle phase clears bit B.
// Finishing the last phase sets both bits together. The illegal code A=1,B=0 is
// pulled back to the first phase. Assumes at most one done is high per cycle.
module seq_state_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic done_first,
    input  logic done_mid,
    input  logic done_last,
    output logic bit_a,
    output logic bit_b
);
    // Set/reset update of the phase bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_a <= 1'b1;
            bit_b <= 1'b1;
        end else if (bit_a && !bit_b) begin
            bit_a <= 1'b1;
            bit_b <= 1'b1;
        end else if (done_last) begin
            bit_a <= 1'b1;
            bit_b <= 1'b1;
        end else begin
            if (done_first) bit_a <= 1'b0;
            if (done_mid)   bit_b <= 1'b0;
        end
    end

    AST_RESET_TO_FIRST: assert property (@(posedge clk)
        !rst_n |=> (bit_a && bit_b)); // R1
    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_a && !bit_b)); // R8
    AST_WRAP_BOTH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_a && !bit_b && done_last) |=> (bit_a && bit_b)); // R8
endmodule

// File: rtl/seq_phase_decode.sv
// Module: decodes the two state bits into the phase code, the one-hot active
// vector and the relay outputs. Purely combinational.
// Assumes the bit encoding A=1,B=1 first; A=0,B=1 middle; A=0,B=0 last.
module seq_phase_decode
    import seq_pkg::*;
(
    input  logic                  bit_a,
    input  logic                  bit_b,
    output logic [1:0]            phase,
    output logic [NUM_PHASES-1:0] act,
    output logic                  relay_first,
    output logic                  relay_last
);
    // Map the state bits to a phase code; the illegal code reads as first.
    always_comb begin
        unique case ({bit_a, bit_b})
            2'b01:   phase = PH_MID;
            2'b00:   phase = PH_LAST;
            default: phase = PH_FIRST;
        endcase
    end

    // Derive the active vector and the relay drives from the phase code.
    always_comb begin
        act[0]      = (phase == PH_FIRST);
        act[1]      = (phase == PH_MID);
        act[2]      = (phase == PH_LAST);
        relay_first = bit_a;
        relay_last  = !bit_b;
    end

    AST_RELAYS_EXCLUSIVE: assert final (!(relay_first && relay_last)); // R3
endmodule

// File: rtl/phase_relay_seq.sv
// Module: top of the three-phase cyclic relay sequencer.
// Has one delay counter per phase, two set/reset state bits and a decoder.
// Assumes tick is a single-cycle enable and the delays are held while in use.
module phase_relay_seq
    import seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] delay_first,
    input  logic [DW-1:0] delay_mid,
    input  logic [DW-1:0] delay_last,
    output logic [1:0]    phase,
    output logic          relay_first,
    output logic          relay_last
);
    logic [NUM_PHASES-1:0] act;
    logic [NUM_PHASES-1:0] done;
    logic [DW-1:0]         delay_vec [NUM_PHASES];
    logic                  bit_a;
    logic                  bit_b;

    // Gather the delay settings so the timers can be generated in a loop.
    always_comb begin
        delay_vec[0] = delay_first;
        delay_vec[1] = delay_mid;
        delay_vec[2] = delay_last;
    end

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_timer
        seq_phase_timer #(.DW(DW)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (act[i]),
            .tick   (tick),
            .target (delay_vec[i]),
            .done   (done[i])
        );
    end

    seq_state_bits u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_first (done[0]),
        .done_mid   (done[1]),
        .done_last  (done[2]),
        .bit_a      (bit_a),
        .bit_b      (bit_b)
    );

    seq_phase_decode u_dec (
        .bit_a       (bit_a),
        .bit_b       (bit_b),
        .phase       (phase),
        .act         (act),
        .relay_first (relay_first),
        .relay_last  (relay_last)
    );

    AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(done) <= 1); // R7
    AST_ORDER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST) |=> (phase == PH_FIRST || phase == PH_MID)); // R2
    AST_ORDER_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MID) |=> (phase == PH_MID || phase == PH_LAST)); // R2
    AST_ORDER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAST) |=> (phase == PH_LAST || phase == PH_FIRST)); // R2
endmodule

// File: tb/phase_relay_seq_test.sv
// Scoreboard bench: the driver pushes the expected phase segments, and the
// monitor pops them when the phase changes and compares.
module phase_relay_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b0;
    logic          tick   = 1'b0;
    logic [DW-1:0] d_first = '0;
    logic [DW-1:0] d_mid   = '0;
    logic [DW-1:0] d_last  = '0;
    logic [1:0]    phase;
    logic          relay_first;
    logic          relay_last;

    typedef struct {
        logic [1:0] ph;
        int         ticks;
        logic [1:0] nxt;
    } seg_t;

    seg_t       exp_q[$];
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         arm_req  = 1'b0;
    bit         armed    = 1'b0;
    logic [1:0] cur_ph;
    int         tick_cnt;
    bit         relay_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_relay_seq #(.DW(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .delay_first (d_first),
        .delay_mid   (d_mid),
        .delay_last  (d_last),
        .phase       (phase),
        .relay_first (relay_first),
        .relay_last  (relay_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] next_ph(input logic [1:0] p);
        return (p == 2'b01) ? 2'b10 : (p == 2'b10) ? 2'b11 : 2'b01;
    endfunction

    // Monitor: counts the ticks seen in each phase and scores every phase change.
    always @(negedge clk) begin
        if (!arm_req) begin
            armed = 1'b0;
        end else begin
            if (!armed) begin
                armed     = 1'b1;
                cur_ph    = phase;
                tick_cnt  = 0;
                relay_bad = 1'b0;
            end
            if (phase != cur_ph) begin
                if (exp_q.size() > 0) begin
                    seg_t e;
                    e = exp_q.pop_front();
                    // R2 order and R8 straight wrap from last to first
                    check(cur_ph == e.ph && phase == e.nxt, "R2/R8", "phase transition",
                          {cur_ph, phase}, {e.ph, e.nxt});
                    // R5 duration, R6 zero delay, R7 counter restarts from zero
                    check(tick_cnt == e.ticks, "R5/R6/R7", "ticks in phase",
                          tick_cnt, e.ticks);
                    check(!relay_bad, "R3/R4", "relays within phase",
                          int'(relay_bad), 0);
                end
                cur_ph    = phase;
                tick_cnt  = 0;
                relay_bad = 1'b0;
            end
            if (tick) tick_cnt++;
            if (relay_first !== (phase == 2'b01) || relay_last !== (phase == 2'b11))
                relay_bad = 1'b1;
        end
    end

    // Driver: reset, push the expected segments, then drive ticks until all are scored.
    task automatic run_case(input int a, input int b, input int c,
                            input int period, input int cycles);
        int extra;
        int cnt;
        extra = (period == 1) ? 1 : 0;
        exp_q.delete();
        d_first = DW'(a);
        d_mid   = DW'(b);
        d_last  = DW'(c);
        for (int k = 0; k < cycles; k++) begin
            exp_q.push_back('{2'b01, a + extra, 2'b10});
            exp_q.push_back('{2'b10, b + extra, 2'b11});
            exp_q.push_back('{2'b11, c + extra, 2'b01});
        end
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n   = 1'b1;
        arm_req = 1'b1;
        cnt     = 0;
        tick    = 1'b1;
        @(negedge clk);
        check(phase == 2'b01, "R1", "phase after reset", phase, 1);
        check(relay_first == 1'b1 && relay_last == 1'b0, "R1", "relays after reset",
              {relay_first, relay_last}, 2);
        while (exp_q.size() > 0) begin
            @(posedge clk);
            #1;
            cnt++;
            tick = ((cnt % period) == 0);
        end
        @(posedge clk);
        #1;
        tick    = 1'b0;
        arm_req = 1'b0;
    endtask

    // Driver: reset asserted in the middle phase must return to the first phase.
    task automatic run_mid_reset();
        d_first = DW'(1);
        d_mid   = DW'(20);
        d_last  = DW'(1);
        rst_n   = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            #1;
            tick = (k % 2 == 0);
        end
        tick = 1'b0;
        @(negedge clk);
        check(phase == 2'b10, "R9", "phase before reset", phase, 2);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(phase == 2'b01, "R9", "phase after mid-phase reset", phase, 1);
        check(relay_first == 1'b1 && relay_last == 1'b0, "R9", "relays after mid-phase reset",
              {relay_first, relay_last}, 2);
    endtask

    initial begin
        run_case(3, 5, 2, 3, 2);   // spaced ticks
        run_case(1, 1, 1, 1, 2);   // tick every cycle: completion meets a tick
        run_case(0, 4, 0, 1, 2);   // zero delays, R6
        run_case(6, 2, 7, 2, 2);   // alternate-cycle ticks
        run_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog: actual %0d expected %0d segments pending", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule